// File: doc/BRIEF.md
# Quad-Channel DAC Code Register Front-End

This block holds the digital codes for a four-channel, 14-bit voltage DAC and decides what each channel converts. A host writes over a parallel bus: a 14-bit word, a 3-bit register address, an active-low chip enable and an active-low write strobe. The strobe is synchronised into the system clock. Its rising edge, taken while chip enable is low, stores the word. The word goes to one channel register, to a shared common-level register, or to all four channel registers at once.

Two overrides change what the channels drive without altering any stored code. A common-select input makes every channel take the common register's code. An asynchronous, active-low clear raises a per-channel ground flag and zeroes every channel code. When clear is released, each channel goes back to its own register, or to the common one while select is high. The analog stages that use these outputs lie outside this block.

Top module: `quad_dac_wr_frontend`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets all five registers to zero. After reset, with clear and select inactive, every channel code reads 0.
- R2: Address 0, 1, 2 or 3 writes only channel register 0, 1, 2 or 3. No other register changes.
- R3: Address 4 writes only the common register. Channel outputs do not change while select is low.
- R4: Address 7 writes the same word into all four channel registers and leaves the common register unchanged.
- R5: A write to address 5 or 6 changes no register.
- R6: A register is written only on the rising edge of host_wr_n, and only when host_cs_n is low at that edge. Holding the strobe low, or strobing with chip enable high, stores nothing. The write shows at the outputs no later than 4 clock cycles after the rising edge.
- R7: While sel_common is high and clear is inactive, every channel drives the common register's code. Channel registers keep their contents, and each channel's own code returns when select falls.
- R8: While clr_n is low, every bit of ch_gnd is 1 and every channel code is 0, with no clock edge needed. While clr_n is high, ch_gnd is all zeros.
- R9: Writes made while clear is low still update the registers. On release, each channel shows its stored or common code as R7 selects.
- R10: Codes are straight binary with bit 13 as the MSB. Channel k's code occupies ch_code bits [14k+13:14k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_d | input | 14 | Write data word |
| host_a | input | 3 | Register address |
| host_cs_n | input | 1 | Chip enable, active low |
| host_wr_n | input | 1 | Write strobe, active low, stores on rising edge |
| sel_common | input | 1 | Drive common register on all channels |
| clr_n | input | 1 | Asynchronous clear to ground level, active low |
| ch_code | output | 56 | Effective code per channel, channel k at [14k+13:14k] |
| ch_gnd | output | 4 | Per-channel force-to-ground flag |

## Verification
The assertions check on every cycle that:
- the clear override drives the ground flags and zero codes,
- the select override makes all channels equal,
- registers stay stable when no write fires or when an unused address is written,
- the decoded write targets take the sampled word.

Other properties need the bench's scenarios to show them, because they depend on what was written earlier:
- the strobe-edge timing;
- the chip-enable gating;
- that stored codes survive select and clear;
- that writes made during clear appear on release.

// File: rtl/quad_dac_wr_frontend.sv
module quad_dac_wr_frontend #(
  parameter int DATA_W      = 14,
  parameter int NCH         = 4,
  parameter int ADDR_W      = 3,
  parameter int COMMON_ADDR = 4,
  parameter int BCAST_ADDR  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_W-1:0]     host_d,
  input  logic [ADDR_W-1:0]     host_a,
  input  logic                  host_cs_n,
  input  logic                  host_wr_n,
  input  logic                  sel_common,
  input  logic                  clr_n,
  output logic [NCH*DATA_W-1:0] ch_code,
  output logic [NCH-1:0]        ch_gnd
);
  localparam int BUS_W = NCH * DATA_W;

  logic wr_s1, wr_s2, wr_prev;
  logic wr_fire;
  logic [DATA_W-1:0] com_q;
  logic [BUS_W-1:0]  chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_s1   <= 1'b1;
      wr_s2   <= 1'b1;
      wr_prev <= 1'b1;
    end else begin
      wr_s1   <= host_wr_n;
      wr_s2   <= wr_s1;
      wr_prev <= wr_s2;
    end
  end

  assign wr_fire = wr_s2 & ~wr_prev & ~host_cs_n;

  always_ff @(posedge clk) begin
    if (!rst_n)
      com_q <= '0;
    else if (wr_fire && host_a == ADDR_W'(COMMON_ADDR))
      com_q <= host_d;
  end

  assign ch_gnd = {NCH{~clr_n}};

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic hit;
    assign hit = wr_fire && (host_a == ADDR_W'(k) || host_a == ADDR_W'(BCAST_ADDR));

    always_ff @(posedge clk) begin
      if (!rst_n)
        chan_q[k*DATA_W +: DATA_W] <= '0;
      else if (hit)
        chan_q[k*DATA_W +: DATA_W] <= host_d;
    end

    assign ch_code[k*DATA_W +: DATA_W] = !clr_n      ? '0 :
                                         sel_common ? com_q :
                                                      chan_q[k*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/quad_dac_wr_frontend_chk.sv
module quad_dac_wr_frontend_chk #(
  parameter int DATA_W      = 14,
  parameter int NCH         = 4,
  parameter int ADDR_W      = 3,
  parameter int COMMON_ADDR = 4,
  parameter int BCAST_ADDR  = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr_n,
  input logic                  sel_common,
  input logic [ADDR_W-1:0]     host_a,
  input logic [DATA_W-1:0]     host_d,
  input logic                  wr_fire,
  input logic [NCH*DATA_W-1:0] chan_q,
  input logic [DATA_W-1:0]     com_q,
  input logic [NCH*DATA_W-1:0] ch_code,
  input logic [NCH-1:0]        ch_gnd
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (chan_q == '0 && com_q == '0));

  assert_clear_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (ch_gnd == {NCH{1'b1}} && ch_code == '0));

  assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n |-> ch_gnd == '0);

  assert_no_write_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> ($stable(chan_q) && $stable(com_q)));

  assert_unused_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && (host_a == 3'd5 || host_a == 3'd6)) |=> ($stable(chan_q) && $stable(com_q)));

  assert_common_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && host_a == ADDR_W'(COMMON_ADDR)) |=> (com_q == $past(host_d) && $stable(chan_q)));

  assert_bcast_keeps_common_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && host_a == ADDR_W'(BCAST_ADDR)) |=> $stable(com_q));

  for (genvar k = 0; k < NCH; k++) begin : g_a
    assert_chan_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && (host_a == ADDR_W'(k) || host_a == ADDR_W'(BCAST_ADDR)))
        |=> chan_q[k*DATA_W +: DATA_W] == $past(host_d));

    if (k > 0) begin : g_eq
      assert_sel_common_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && sel_common) |-> ch_code[k*DATA_W +: DATA_W] == ch_code[DATA_W-1:0]);
    end
  end
endmodule

bind quad_dac_wr_frontend quad_dac_wr_frontend_chk #(
  .DATA_W(DATA_W), .NCH(NCH), .ADDR_W(ADDR_W),
  .COMMON_ADDR(COMMON_ADDR), .BCAST_ADDR(BCAST_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sel_common(sel_common),
  .host_a(host_a), .host_d(host_d), .wr_fire(wr_fire),
  .chan_q(chan_q), .com_q(com_q), .ch_code(ch_code), .ch_gnd(ch_gnd)
);

// File: tb/quad_dac_wr_frontend_tb_top.sv
`timescale 1ns/1ps
module quad_dac_wr_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] host_d = '0;
  logic [2:0]  host_a = '0;
  logic        host_cs_n = 1'b1;
  logic        host_wr_n = 1'b1;
  logic        sel_common = 1'b0;
  logic        clr_n = 1'b1;
  logic [55:0] ch_code;
  logic [3:0]  ch_gnd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [13:0] m_ch [4];
  logic [13:0] m_e;

  always #10 clk = ~clk;

  quad_dac_wr_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .host_d(host_d), .host_a(host_a),
    .host_cs_n(host_cs_n), .host_wr_n(host_wr_n), .sel_common(sel_common),
    .clr_n(clr_n), .ch_code(ch_code), .ch_gnd(ch_gnd)
  );

  task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [13:0] expect_ch(input int k);
    if (!clr_n) return 14'h0;
    if (sel_common) return m_e;
    return m_ch[k];
  endfunction

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++) chk(req, ch_code[k*14 +: 14], expect_ch(k));
    chk(req, {10'h0, ch_gnd}, clr_n ? 14'h0 : 14'hF);
  endtask

  task automatic host_write(input logic [2:0] a, input logic [13:0] d, input logic cs_n);
    @(negedge clk);
    host_a = a; host_d = d; host_cs_n = cs_n; host_wr_n = 1'b0;
    repeat (5) @(negedge clk);
    check_all("R6 strobe low stores nothing");
    host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    host_cs_n = 1'b1;
    if (!cs_n) begin
      if (a <= 3'd3) m_ch[a] = d;
      else if (a == 3'd4) m_e = d;
      else if (a == 3'd7) for (int k = 0; k < 4; k++) m_ch[k] = d;
    end
  endtask

  task automatic peek_common(input string req);
    @(negedge clk); sel_common = 1'b1;
    @(negedge clk); check_all(req);
    sel_common = 1'b0;
    @(negedge clk); check_all("R7 own codes return");
  endtask

  initial begin
    for (int k = 0; k < 4; k++) m_ch[k] = '0;
    m_e = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset state");
    peek_common("R1 common reset");

    for (int pass = 0; pass < 3; pass++) begin
      for (int a = 0; a < 8; a++) begin
        logic [13:0] d;
        d = 14'((a * 16'h0913 + pass * 16'h1555 + 16'h00A5) & 16'h3FFF);
        host_write(3'(a), d, 1'b0);
        case (a)
          0, 1, 2, 3: check_all("R2 channel write");
          4: check_all("R3 common write hidden");
          7: check_all("R4 broadcast");
          default: check_all("R5 unused address");
        endcase
        peek_common(a == 7 ? "R4 common kept" : "R7 select common");
      end
    end

    host_write(3'd1, 14'h2000, 1'b0);
    chk("R10 msb position", {13'h0, ch_code[27]}, 14'h1);
    chk("R10 channel1 field", ch_code[27:14], 14'h2000);
    host_write(3'd3, 14'h3FFF, 1'b0);
    chk("R10 full scale", ch_code[55:42], 14'h3FFF);
    host_write(3'd0, 14'h0001, 1'b0);
    chk("R10 lsb", ch_code[13:0], 14'h0001);

    host_write(3'd2, 14'h1234, 1'b1);
    check_all("R6 chip enable high ignored");
    host_write(3'd7, 14'h0F0F, 1'b1);
    check_all("R6 broadcast ignored when disabled");

    @(negedge clk); clr_n = 1'b0; #1;
    check_all("R8 clear immediate");
    host_write(3'd2, 14'h2ABC, 1'b0);
    check_all("R8 clear holds during write");
    host_write(3'd4, 14'h1DEF, 1'b0);
    sel_common = 1'b1;
    @(negedge clk); check_all("R8 clear over select");
    clr_n = 1'b1; #1;
    check_all("R9 release with select");
    sel_common = 1'b0; #1;
    check_all("R9 release own codes");
    chk("R9 write during clear", ch_code[41:28], 14'h2ABC);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) m_ch[k] = '0;
    m_e = '0;
    @(negedge clk); check_all("R1 reset after use");
    peek_common("R1 common after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule